// File: doc/BRIEF.md
# Framebuffer Scanout Address Generator

This block turns a programmed frame origin and line stride into the sequence of memory word addresses that display refresh fetches. The timing generator supplies three strobes: a frame strobe that begins line 0, a line strobe that begins each following line, and a fetch strobe for each 32-bit word read within a line. The block answers with the current word fetch address and with the byte offset (0 to 3) of the first visible pixel inside the first word of each line.

Software programs four fields through a small write port: the frame origin as a 32-bit-word address, a byte pan value, the line stride in units of 8 bytes, and the visible height in lines. The origin and the pan go into holding registers. They become live only when the raster line counter reaches the visible height, which is the start of vertical retrace. A page flip written during active display therefore never changes the address stream in the middle of a frame. The stride and the height are used as soon as they are written. The block also presents the raster line counter and a retrace flag, so that software can poll them before it flips.

Top module: `scanout_addr_gen`

## Requirements
- R1: After reset, fetch_word, pix_pan and raster_line are 0, and in_retrace is 1 because the height field resets to 0.
- R2: A write with cfg_sel=0 stores cfg_wdata[31:2] as the pending origin word address, and cfg_wdata[1:0] is ignored. A write with cfg_sel=1 stores cfg_wdata[2:1] as the pending byte pan, and cfg_wdata[0] and cfg_wdata[31:3] are ignored. Pending values do not change fetch_word or pix_pan at any later frame strobe until they have been made live.
- R3: The pending origin and pan become live on the clock edge of a line strobe (one without a frame strobe) that moves raster_line from height-1 to height. No other event changes the live values.
- R4: A frame strobe sets fetch_word to the live origin, pix_pan to the live pan and raster_line to 0 on the next edge. It overrides a line strobe and a fetch strobe in the same cycle. pix_pan changes only on a frame strobe.
- R5: A line strobe without a frame strobe adds pitch×2 words (pitch×8 bytes) to the line base and sets fetch_word to the new base. It also increments raster_line, which saturates at 2047.
- R6: A fetch strobe alone increments fetch_word by one, wrapping modulo 2^30. With no strobe, fetch_word and raster_line hold.
- R7: in_retrace is 1 exactly when raster_line is greater than or equal to the programmed height.
- R8: A write with cfg_sel=2 sets the 11-bit pitch from cfg_wdata[10:0], and upper bits are ignored. The new pitch is used by the very next line strobe. cfg_sel=3 sets the 11-bit height from cfg_wdata[10:0].
- R9: When an origin write and a make-live event fall in the same cycle, the live origin receives the value that was pending before the write. The written value waits for the next retrace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Field write strobe |
| cfg_sel | input | 2 | Field select: 0 origin, 1 pan, 2 pitch, 3 height |
| cfg_wdata | input | 32 | Write data |
| frame_start | input | 1 | Begin of frame (line 0) |
| line_start | input | 1 | Begin of each following line |
| fetch | input | 1 | One 32-bit word fetched |
| fetch_word | output | 30 | Current word fetch address (byte address bits 31:2) |
| pix_pan | output | 2 | Byte offset of the first pixel in each line |
| raster_line | output | 11 | Raster line counter |
| in_retrace | output | 1 | Raster line at or past the visible height |

## Verification
A wrong line base shows up at the first line strobe after it: fetch_word is then off by a multiple of the stride and stays off for the rest of the frame, until the next frame strobe reloads it. A wrong live origin or pan remains hidden until the next frame strobe and then shows up in the first fetch address of that frame. A make-live event at the wrong line is seen only one frame later. For this reason the stimulus flips the origin at the retrace line and then on either side of it. A raster counter error shows at once on raster_line and in_retrace, and one frame later as a flip that was missed or taken at the wrong time.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [1:0] {
    SEL_ORIGIN = 2'd0,
    SEL_PAN    = 2'd1,
    SEL_PITCH  = 2'd2,
    SEL_HEIGHT = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/scan_regs.sv
module scan_regs #(
  parameter int ADDR_W     = 32,
  parameter int PITCH_W    = 11,
  parameter int LINE_W     = 11,
  parameter bit PITCH_LIVE = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_sel,
  input  logic [ADDR_W-1:0]   cfg_wdata,
  input  logic                make_live,
  output logic [ADDR_W-3:0]   live_origin,
  output logic [1:0]          live_pan,
  output logic [PITCH_W-1:0]  pitch,
  output logic [LINE_W-1:0]   height
);
  import scan_pkg::*;
  localparam int WA = ADDR_W - 2;

  logic [WA-1:0]      pend_origin_q, pend_origin_d;
  logic [1:0]         pend_pan_q, pend_pan_d;
  logic [WA-1:0]      live_origin_q, live_origin_d;
  logic [1:0]         live_pan_q, live_pan_d;
  logic [LINE_W-1:0]  height_q, height_d;
  logic               wr_origin, wr_pan, wr_pitch, wr_height;

  logic unused_wdata;
  assign unused_wdata = ^{cfg_wdata[1:0], cfg_wdata[0]};

  always_comb begin
    wr_origin = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_ORIGIN);
    wr_pan    = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_PAN);
    wr_pitch  = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_PITCH);
    wr_height = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_HEIGHT);
  end

  always_comb begin
    pend_origin_d = pend_origin_q;
    pend_pan_d    = pend_pan_q;
    live_origin_d = live_origin_q;
    live_pan_d    = live_pan_q;
    height_d      = height_q;
    if (wr_origin) pend_origin_d = cfg_wdata[ADDR_W-1:2];
    if (wr_pan)    pend_pan_d    = cfg_wdata[2:1];
    if (wr_height) height_d      = cfg_wdata[LINE_W-1:0];
    // retrace copy takes the value held before this cycle's write
    if (make_live) begin
      live_origin_d = pend_origin_q;
      live_pan_d    = pend_pan_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_origin_q <= '0;
      pend_pan_q    <= '0;
      live_origin_q <= '0;
      live_pan_q    <= '0;
      height_q      <= '0;
    end else begin
      pend_origin_q <= pend_origin_d;
      pend_pan_q    <= pend_pan_d;
      live_origin_q <= live_origin_d;
      live_pan_q    <= live_pan_d;
      height_q      <= height_d;
    end
  end

  generate
    if (PITCH_LIVE) begin : g_pitch_direct
      logic [PITCH_W-1:0] pitch_q, pitch_d;
      always_comb begin
        pitch_d = pitch_q;
        if (wr_pitch) pitch_d = cfg_wdata[PITCH_W-1:0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pitch_q <= '0;
        else        pitch_q <= pitch_d;
      end
      assign pitch = pitch_q;
    end else begin : g_pitch_staged
      logic [PITCH_W-1:0] pend_q, pend_d, act_q, act_d;
      always_comb begin
        pend_d = pend_q;
        act_d  = act_q;
        if (wr_pitch)  pend_d = cfg_wdata[PITCH_W-1:0];
        if (make_live) act_d  = pend_q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pend_q <= '0;
          act_q  <= '0;
        end else begin
          pend_q <= pend_d;
          act_q  <= act_d;
        end
      end
      assign pitch = act_q;
    end
  endgenerate

  assign live_origin = live_origin_q;
  assign live_pan    = live_pan_q;
  assign height      = height_q;
endmodule

// File: rtl/scan_raster.sv
module scan_raster #(
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic [LINE_W-1:0] height,
  output logic [LINE_W-1:0] line_cnt,
  output logic              in_retrace,
  output logic              make_live
);
  localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

  logic [LINE_W-1:0] cnt_q, cnt_d;
  logic [LINE_W:0]   cnt_plus;
  logic              cnt_en;

  always_comb begin
    cnt_plus  = {1'b0, cnt_q} + {{LINE_W{1'b0}}, 1'b1};
    cnt_en    = frame_start || line_start;
    cnt_d     = cnt_q;
    make_live = 1'b0;
    if (frame_start) begin
      cnt_d = '0;
    end else if (line_start) begin
      if (cnt_q != LINE_MAX) cnt_d = cnt_plus[LINE_W-1:0];
      // 12-bit compare: a saturated counter never matches again
      make_live = (cnt_plus == {1'b0, height});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign line_cnt   = cnt_q;
  assign in_retrace = (cnt_q >= height);
endmodule

// File: rtl/scan_addr.sv
module scan_addr #(
  parameter int ADDR_W  = 32,
  parameter int PITCH_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               line_start,
  input  logic               fetch,
  input  logic [ADDR_W-3:0]  live_origin,
  input  logic [1:0]         live_pan,
  input  logic [PITCH_W-1:0] pitch,
  output logic [ADDR_W-3:0]  fetch_word,
  output logic [1:0]         pix_pan
);
  localparam int WA  = ADDR_W - 2;
  localparam int PAD = WA - PITCH_W - 1;

  logic [WA-1:0] base_q, base_d, ptr_q, ptr_d, stride_w;
  logic [1:0]    pan_q, pan_d;
  logic          base_en, ptr_en, pan_en;

  always_comb begin
    // pitch counts 8-byte units, i.e. two 32-bit words
    stride_w = {{PAD{1'b0}}, pitch, 1'b0};
    base_d   = base_q;
    ptr_d    = ptr_q;
    pan_d    = pan_q;
    base_en  = frame_start || line_start;
    ptr_en   = frame_start || line_start || fetch;
    pan_en   = frame_start;
    if (frame_start) begin
      base_d = live_origin;
      ptr_d  = live_origin;
      pan_d  = live_pan;
    end else if (line_start) begin
      base_d = base_q + stride_w;
      ptr_d  = base_q + stride_w;
    end else if (fetch) begin
      ptr_d  = ptr_q + {{(WA-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ptr_q  <= '0;
      pan_q  <= '0;
    end else begin
      if (base_en) base_q <= base_d;
      if (ptr_en)  ptr_q  <= ptr_d;
      if (pan_en)  pan_q  <= pan_d;
    end
  end

  assign fetch_word = ptr_q;
  assign pix_pan    = pan_q;
endmodule

// File: rtl/scanout_addr_gen.sv
module scanout_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int PITCH_W    = 11,
  parameter int LINE_W     = 11,
  parameter bit PITCH_LIVE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              fetch,
  output logic [ADDR_W-3:0] fetch_word,
  output logic [1:0]        pix_pan,
  output logic [LINE_W-1:0] raster_line,
  output logic              in_retrace
);
  logic [ADDR_W-3:0]  live_origin;
  logic [1:0]         live_pan;
  logic [PITCH_W-1:0] pitch;
  logic [LINE_W-1:0]  height;
  logic               make_live;

  scan_regs #(
    .ADDR_W(ADDR_W), .PITCH_W(PITCH_W), .LINE_W(LINE_W), .PITCH_LIVE(PITCH_LIVE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .make_live(make_live), .live_origin(live_origin),
    .live_pan(live_pan), .pitch(pitch), .height(height)
  );

  scan_raster #(.LINE_W(LINE_W)) u_raster (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
    .height(height), .line_cnt(raster_line), .in_retrace(in_retrace),
    .make_live(make_live)
  );

  scan_addr #(.ADDR_W(ADDR_W), .PITCH_W(PITCH_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
    .fetch(fetch), .live_origin(live_origin), .live_pan(live_pan), .pitch(pitch),
    .fetch_word(fetch_word), .pix_pan(pix_pan)
  );
endmodule

// File: rtl/scanout_addr_gen_chk.sv
module scanout_addr_gen_chk #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              line_start,
  input logic              fetch,
  input logic [ADDR_W-3:0] fetch_word,
  input logic [1:0]        pix_pan,
  input logic [LINE_W-1:0] raster_line,
  input logic [ADDR_W-3:0] live_origin
);
  AST_FRAME_CLEARS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> raster_line == '0); // R4

  AST_PAN_ONLY_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(pix_pan)); // R4

  AST_LINE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !frame_start && raster_line != {LINE_W{1'b1}})
      |=> raster_line == $past(raster_line) + 1'b1); // R5

  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && !frame_start && !line_start)
      |=> fetch_word == $past(fetch_word) + 1'b1); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch && !frame_start && !line_start)
      |=> ($stable(fetch_word) && $stable(raster_line))); // R6

  AST_ORIGIN_ONLY_AT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start || frame_start) |=> $stable(live_origin)); // R3
endmodule

bind scanout_addr_gen scanout_addr_gen_chk #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
  .fetch(fetch), .fetch_word(fetch_word), .pix_pan(pix_pan),
  .raster_line(raster_line), .live_origin(live_origin)
);

// File: tb/tb_scanout_addr_gen.sv
`timescale 1ns/1ps
module tb_scanout_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        frame_start, line_start, fetch;
  logic [29:0] fetch_word;
  logic [1:0]  pix_pan;
  logic [10:0] raster_line;
  logic        in_retrace;

  int n_chk = 0;
  int n_bad = 0;

  // bench model state
  logic [29:0] m_pend, m_live, m_base, m_ptr;
  logic [1:0]  m_ppan, m_lpan, m_pan;
  logic [10:0] m_pitch, m_h, m_cnt;

  always #2 clk = ~clk;

  scanout_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .frame_start(frame_start), .line_start(line_start),
    .fetch(fetch), .fetch_word(fetch_word), .pix_pan(pix_pan),
    .raster_line(raster_line), .in_retrace(in_retrace)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [29:0] stride(input logic [10:0] p);
    return {18'd0, p, 1'b0};
  endfunction

  task automatic model_edge(input bit we, input logic [1:0] a, input logic [31:0] d,
                            input bit fs, input bit ls, input bit ft);
    bit lat;
    lat = ls && !fs && ({1'b0, m_cnt} + 12'd1 == {1'b0, m_h});
    if (fs) begin
      m_base = m_live; m_ptr = m_live; m_pan = m_lpan; m_cnt = '0;
    end else if (ls) begin
      m_base = m_base + stride(m_pitch); m_ptr = m_base;
      if (m_cnt != 11'h7ff) m_cnt = m_cnt + 11'd1;
    end else if (ft) begin
      m_ptr = m_ptr + 30'd1;
    end
    if (lat) begin m_live = m_pend; m_lpan = m_ppan; end
    if (we) begin
      case (a)
        2'd0: m_pend  = d[31:2];
        2'd1: m_ppan  = d[2:1];
        2'd2: m_pitch = d[10:0];
        default: m_h  = d[10:0];
      endcase
    end
  endtask

  task automatic step(input bit we, input logic [1:0] a, input logic [31:0] d,
                      input bit fs, input bit ls, input bit ft);
    @(negedge clk);
    cfg_we = we; cfg_sel = a; cfg_wdata = d;
    frame_start = fs; line_start = ls; fetch = ft;
    @(posedge clk);
    model_edge(we, a, d, fs, ls, ft);
    #1;
    chk("R4/R5/R6 fetch_word", {2'b0, fetch_word}, {2'b0, m_ptr});
    chk("R2/R3/R4 pix_pan", {30'd0, pix_pan}, {30'd0, m_pan});
    chk("R5 raster_line", {21'd0, raster_line}, {21'd0, m_cnt});
    chk("R7 in_retrace", {31'd0, in_retrace}, {31'd0, (m_cnt >= m_h)});
  endtask

  task automatic idle();
    step(0, 2'd0, 32'd0, 0, 0, 0);
  endtask

  initial begin
    #(4 * 190000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 1'b0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    frame_start = 0; line_start = 0; fetch = 0;
    m_pend = 0; m_live = 0; m_base = 0; m_ptr = 0;
    m_ppan = 0; m_lpan = 0; m_pan = 0; m_pitch = 0; m_h = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 fetch_word", {2'b0, fetch_word}, 32'd0);
    chk("R1 pix_pan", {30'd0, pix_pan}, 32'd0);
    chk("R1 raster_line", {21'd0, raster_line}, 32'd0);
    chk("R1 in_retrace", {31'd0, in_retrace}, 32'd1);

    // directed sequence
    step(1, 2'd3, 32'd2, 0, 0, 0);            // height 2
    step(1, 2'd2, 32'h0000_0810, 0, 0, 0);    // R8 pitch: bit 11 ignored -> 0x10
    step(1, 2'd0, 32'h0000_0107, 0, 0, 0);    // origin word 0x41
    step(1, 2'd1, 32'hFFFF_FFFF, 0, 0, 0);    // pan offset 3
    step(0, 2'd0, 32'd0, 1, 0, 0);
    chk("R2 pending origin not live", {2'b0, fetch_word}, 32'd0);
    chk("R2 pending pan not live", {30'd0, pix_pan}, 32'd0);
    step(0, 2'd0, 32'd0, 0, 1, 0);
    chk("R8 pitch stride 32 words", {2'b0, fetch_word}, 32'd32);
    chk("R7 not in retrace", {31'd0, in_retrace}, 32'd0);
    step(1, 2'd0, 32'h0000_2000, 0, 1, 0);    // write with make-live
    chk("R5 second line base", {2'b0, fetch_word}, 32'd64);
    chk("R7 retrace at height", {31'd0, in_retrace}, 32'd1);
    step(0, 2'd0, 32'd0, 1, 0, 0);
    chk("R9 old pending origin live", {2'b0, fetch_word}, 32'h41);
    chk("R3 pan live", {30'd0, pix_pan}, 32'd3);
    step(0, 2'd0, 32'd0, 0, 0, 1);
    chk("R6 fetch step", {2'b0, fetch_word}, 32'h42);
    step(0, 2'd0, 32'd0, 0, 1, 1);
    chk("R5 line over fetch", {2'b0, fetch_word}, 32'h61);
    step(0, 2'd0, 32'd0, 0, 1, 0);
    step(0, 2'd0, 32'd0, 1, 1, 1);
    chk("R4 frame priority", {2'b0, fetch_word}, 32'h800);
    chk("R4 frame clears line", {21'd0, raster_line}, 32'd0);
    step(1, 2'd1, 32'h0000_0004, 0, 0, 0);    // pan offset 2, not live yet
    step(0, 2'd0, 32'd0, 0, 0, 1);
    chk("R4 pan holds without frame", {30'd0, pix_pan}, 32'd3);

    // R6 wrap
    step(1, 2'd0, 32'hFFFF_FFFD, 0, 0, 0);
    step(1, 2'd3, 32'd1, 0, 0, 0);
    step(0, 2'd0, 32'd0, 1, 0, 0);
    step(0, 2'd0, 32'd0, 0, 1, 0);
    step(0, 2'd0, 32'd0, 1, 0, 0);
    chk("R6 top word", {2'b0, fetch_word}, 32'h3FFF_FFFF);
    chk("R2 pan offset 2", {30'd0, pix_pan}, 32'd2);
    step(0, 2'd0, 32'd0, 0, 0, 1);
    chk("R6 wrap to zero", {2'b0, fetch_word}, 32'd0);

    // R5 saturation
    step(1, 2'd3, 32'd0, 0, 0, 0);
    for (int i = 0; i < 2050; i++) step(0, 2'd0, 32'd0, 0, 1, 0);
    chk("R5 saturate", {21'd0, raster_line}, 32'h7FF);
    idle();

    // random traffic with retrace-aligned flips
    step(1, 2'd3, 32'd6, 0, 0, 0);
    step(0, 2'd0, 32'd0, 1, 0, 0);
    for (int i = 0; i < 20000; i++) begin
      bit we, fs, ls, ft;
      logic [1:0] a;
      logic [31:0] d;
      we = ($urandom_range(0, 9) == 0);
      a  = 2'($urandom_range(0, 3));
      d  = $urandom();
      if (a == 2'd3) d = {$urandom_range(0, 2047) < 100 ? 32'($urandom_range(0, 12)) : d};
      fs = ($urandom_range(0, 149) == 0);
      ls = ($urandom_range(0, 11) == 0);
      ft = ($urandom_range(0, 1) == 0);
      step(we, a, d, fs, ls, ft);
    end
    idle();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule